// File: doc/BRIEF.md
# Dual-Reference Card Clock Divider

This block sets the card bus clock of a memory-card host. Two reference tick streams arrive at the block, one from a 20 MHz source and one from a 24 MHz source. Software issues a requested card frequency in hertz. For each reference the block works out the smallest divider whose output does not exceed the request. It then keeps the reference whose divided rate comes out higher. Both dividers are computed by sequential shift-subtract dividers that run side by side, so a new setting takes a fixed number of cycles to appear.

The chosen divider is exposed as a 10-bit field together with a flag that marks the 24 MHz reference. A gating stage turns the selected reference ticks into a one-cycle clock-enable strobe, one strobe per divider ticks. The gating stage picks up a new setting only where a strobe is issued, so the card clock never sees a clipped phase. A request of zero parks the divider at 0, and that stops the strobe.

Top module: `cardclk_dualref`

## Requirements
- R1: After reset `div_o` is 61, `ref_fast_o` is 0 (20 MHz reference), `busy_o` and `done_o` are 0, and `clk_en_o` pulses once every 61 ticks of `tick_slow_i`.
- R2: For each reference frequency F and a nonzero request Q, the divider is d = floor(F/Q), raised to 1 if it is 0, then raised by one more if floor(F/d) > Q.
- R3: `ref_fast_o` becomes 0 only when floor(20e6/d20) is strictly greater than floor(24e6/d24); on a tie or otherwise it becomes 1 and the 24 MHz divider is used.
- R4: `div_o` holds bits 9..0 of the selected divider; higher bits are dropped.
- R5: A zero request sets `div_o` to 0 and leaves `ref_fast_o` as it was, with `done_o` high in the cycle after the edge that samples `start_i`; once adopted, `clk_en_o` stays low.
- R6: A nonzero request sets `busy_o` from the sampling edge; `done_o` pulses and `div_o`/`ref_fast_o` change exactly 2*FREQ_W+3 edges (53 by default) after the sampling edge, and at no other time.
- R7: A `start_i` pulse while `busy_o` is 1 is ignored: the running result and its timing are unchanged.
- R8: `clk_en_o` is a one-cycle pulse once every `div` ticks of the selected tick input (`tick_fast_i` when the active reference flag is 1); a divider of 1 pulses on every tick, a divider of 0 never pulses.
- R9: The gating stage adopts a new setting only in the cycle it issues a strobe with the old setting (at once if the old divider is 0), and restarts its tick count there, so the next strobe follows exactly `div` new ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe, sampled when not busy |
| req_hz_i | input | FREQ_W | Requested card frequency in hertz |
| tick_slow_i | input | 1 | One-cycle tick at the 20 MHz reference rate |
| tick_fast_i | input | 1 | One-cycle tick at the 24 MHz reference rate |
| busy_o | output | 1 | Divider search in progress |
| done_o | output | 1 | One-cycle pulse when a new setting is stored |
| ref_fast_o | output | 1 | 1 selects the 24 MHz reference |
| div_o | output | DIV_W | Stored 10-bit divider field |
| clk_en_o | output | 1 | Card clock enable strobe |

## Verification
A nonzero request yields `done_o`, `div_o` and `ref_fast_o` 53 edges after the sampling edge and a zero request yields them one edge after; the bench counts posedges from the sampling edge and checks the exact distance at which `done_o` is first seen, then reads the outputs in that same cycle. Strobe spacing is due only after the setting has been adopted, so the bench skips the adoption strobe and measures the gap between the next two, or, for a same-reference change, the gap from the adoption strobe to the first new one. Reference ticks come every 6 (slow) and 5 (fast) cycles, so each expected gap is the divider times that period.

// File: rtl/cardclk_pkg.sv
// Shared types and constants of the dual-reference card clock divider.
package cardclk_pkg;
    // number of reference lanes searched in parallel
    localparam int CARDCLK_NREF = 2;

    // per-lane sequencing: first quotient, then resulting frequency
    typedef enum logic [1:0] {
        LN_IDLE = 2'd0,
        LN_QUOT = 2'd1,
        LN_FREQ = 2'd2
    } lane_state_t;
endpackage

// File: rtl/cardclk_seqdiv.sv
// Restoring shift-subtract divider, one quotient bit per cycle.
// Assumes den_i is nonzero when go_i is high. quo_o is valid and done_o
// pulses for one cycle exactly W cycles after the cycle that samples go_i.
module cardclk_seqdiv #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] quo_o,
    output logic         done_o
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, quo_q, den_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [W:0]    shifted, trial;

    // one step: bring in the next dividend bit and try a subtraction
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        trial   = shifted - {1'b0, den_q};
    end

    // iterate W steps after a start, then flag completion for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_o <= 1'b0;
        end else if (go_i) begin
            rem_q  <= '0;
            quo_q  <= num_i;
            den_q  <= den_i;
            cnt_q  <= CW'(W);
            run_q  <= 1'b1;
            done_o <= 1'b0;
        end else if (run_q) begin
            if (!trial[W]) begin
                rem_q <= trial[W-1:0];
                quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
                rem_q <= shifted[W-1:0];
                quo_q <= {quo_q[W-2:0], 1'b0};
            end
            cnt_q  <= cnt_q - CW'(1);
            run_q  <= (cnt_q != CW'(1));
            done_o <= (cnt_q == CW'(1));
        end else begin
            done_o <= 1'b0;
        end
    end

    assign quo_o = quo_q;
endmodule

// File: rtl/cardclk_lane.sv
// Divider search for one reference frequency. On go_i it computes the
// rounded-up divider for the request, then the frequency that divider
// yields. Assumes req_i is nonzero at go_i and REF_HZ < 2**W.
// done_o pulses 2*W+2 edges after the edge that samples go_i.
module cardclk_lane
    import cardclk_pkg::*;
#(
    parameter int W      = 25,
    parameter int REF_HZ = 20_000_000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] req_i,
    output logic         done_o,
    output logic [W-1:0] div_o,
    output logic [W-1:0] freq_o
);
    localparam int PW = 2 * W + 1;

    lane_state_t  st_q;
    logic [W-1:0] req_q, quo, qmin, dadj, den;
    logic         dv_go, dv_done, over;
    logic [PW-1:0] ref_wide, bound;

    // round-up test: floor(ref/d) > req is the same as ref >= (req+1)*d
    always_comb begin
        qmin     = (quo == '0) ? W'(1) : quo;
        ref_wide = PW'(REF_HZ);
        bound    = (PW'(req_q) + PW'(1)) * PW'(qmin);
        over     = (ref_wide >= bound);
        dadj     = over ? (qmin + W'(1)) : qmin;
        dv_go    = ((st_q == LN_IDLE) && go_i) || ((st_q == LN_QUOT) && dv_done);
        den      = (st_q == LN_IDLE) ? req_i : dadj;
    end

    cardclk_seqdiv #(.W(W)) div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (dv_go),
        .num_i  (W'(REF_HZ)),
        .den_i  (den),
        .quo_o  (quo),
        .done_o (dv_done)
    );

    // sequence the two divisions and hold the lane results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= LN_IDLE;
            req_q  <= '0;
            div_o  <= '0;
            freq_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (st_q)
                LN_IDLE: if (go_i) begin
                    req_q <= req_i;
                    st_q  <= LN_QUOT;
                end
                LN_QUOT: if (dv_done) begin
                    div_o <= dadj;
                    st_q  <= LN_FREQ;
                end
                LN_FREQ: if (dv_done) begin
                    freq_o <= quo;
                    done_o <= 1'b1;
                    st_q   <= LN_IDLE;
                end
                default: st_q <= LN_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cardclk_gate.sv
// Turns the selected reference tick stream into a clock-enable strobe,
// one strobe per div ticks. A pending setting is taken only on a strobe
// (or at once while stopped with divider 0), so no phase is clipped.
module cardclk_gate #(
    parameter int DIV_W     = 10,
    parameter int RESET_DIV = 61
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_slow_i,
    input  logic             tick_fast_i,
    input  logic             pend_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             fast_i,
    output logic             take_o,
    output logic             clk_en_o,
    output logic [DIV_W-1:0] act_div_o,
    output logic             act_fast_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             tick, wrap;

    // pick the tick stream of the active reference and detect period end
    always_comb begin
        tick   = act_fast_o ? tick_fast_i : tick_slow_i;
        wrap   = (act_div_o != '0) && tick && (cnt_q == act_div_o - DIV_W'(1));
        take_o = pend_i && ((act_div_o == '0) || wrap);
    end

    // count ticks, strobe at the period end and adopt pending settings there
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_div_o  <= DIV_W'(RESET_DIV);
            act_fast_o <= 1'b0;
            cnt_q      <= '0;
            clk_en_o   <= 1'b0;
        end else begin
            clk_en_o <= wrap;
            if (take_o) begin
                act_div_o  <= div_i;
                act_fast_o <= fast_i;
                cnt_q      <= '0;
            end else if (wrap) begin
                cnt_q <= '0;
            end else if (tick && (act_div_o != '0)) begin
                cnt_q <= cnt_q + DIV_W'(1);
            end
        end
    end
endmodule

// File: rtl/cardclk_dualref.sv
// Top of the dual-reference card clock divider. Runs one search lane per
// reference, keeps the reference giving the higher rounded-down rate
// (24 MHz on a tie), stores the 10-bit divider field and hands it to the
// gating stage. Assumes tick inputs are one-cycle pulses in the clk domain.
module cardclk_dualref
    import cardclk_pkg::*;
#(
    parameter int FREQ_W      = 25,
    parameter int DIV_W       = 10,
    parameter int REF_SLOW_HZ = 20_000_000,
    parameter int REF_FAST_HZ = 24_000_000,
    parameter int RESET_DIV   = 61
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [FREQ_W-1:0] req_hz_i,
    input  logic              tick_slow_i,
    input  logic              tick_fast_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              ref_fast_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              clk_en_o
);
    localparam int NREF = CARDCLK_NREF;

    logic [NREF-1:0]   lane_done;
    logic [FREQ_W-1:0] lane_div  [NREF];
    logic [FREQ_W-1:0] lane_freq [NREF];
    logic              accept, lane_go, sel_fast, pend_q, take;
    logic [DIV_W-1:0]  act_div;
    logic              act_fast;

    // a request is taken only while idle; zero needs no search
    always_comb begin
        accept   = start_i && !busy_o;
        lane_go  = accept && (req_hz_i != '0);
        sel_fast = !(lane_freq[0] > lane_freq[1]);
    end

    for (genvar gi = 0; gi < NREF; gi++) begin : g_lane
        cardclk_lane #(
            .W      (FREQ_W),
            .REF_HZ (gi == 0 ? REF_SLOW_HZ : REF_FAST_HZ)
        ) lane_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .go_i   (lane_go),
            .req_i  (req_hz_i),
            .done_o (lane_done[gi]),
            .div_o  (lane_div[gi]),
            .freq_o (lane_freq[gi])
        );
    end

    // store the chosen setting and keep it pending until the gate takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o     <= 1'b0;
            done_o     <= 1'b0;
            ref_fast_o <= 1'b0;
            div_o      <= DIV_W'(RESET_DIV);
            pend_q     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (accept && (req_hz_i == '0)) begin
                div_o  <= '0;
                done_o <= 1'b1;
                pend_q <= 1'b1;
            end else if (accept) begin
                busy_o <= 1'b1;
            end else if (busy_o && (&lane_done)) begin
                busy_o     <= 1'b0;
                done_o     <= 1'b1;
                ref_fast_o <= sel_fast;
                div_o      <= sel_fast ? lane_div[1][DIV_W-1:0] : lane_div[0][DIV_W-1:0];
                pend_q     <= 1'b1;
            end else if (take) begin
                pend_q <= 1'b0;
            end
        end
    end

    cardclk_gate #(
        .DIV_W     (DIV_W),
        .RESET_DIV (RESET_DIV)
    ) gate_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_slow_i (tick_slow_i),
        .tick_fast_i (tick_fast_i),
        .pend_i      (pend_q),
        .div_i       (div_o),
        .fast_i      (ref_fast_o),
        .take_o      (take),
        .clk_en_o    (clk_en_o),
        .act_div_o   (act_div),
        .act_fast_o  (act_fast)
    );
endmodule

// File: rtl/cardclk_chk.sv
// Property checker for cardclk_dualref, attached by bind below.
module cardclk_chk #(
    parameter int FREQ_W = 25,
    parameter int DIV_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [FREQ_W-1:0] req_hz_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              ref_fast_o,
    input logic [DIV_W-1:0]  div_o,
    input logic              clk_en_o,
    input logic [DIV_W-1:0]  act_div,
    input logic              act_fast,
    input logic [1:0]        lane_done
);
    // R5
    zero_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && req_hz_i == '0) |=> (done_o && div_o == '0 && $stable(ref_fast_o)));

    // R6
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && req_hz_i != '0) |=> (busy_o && !done_o));

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(div_o) && $stable(ref_fast_o)));

    // R6
    lane_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_done[0] == lane_done[1]);

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !(&lane_done)) |=> busy_o);

    // R8
    stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_div == '0) |=> !clk_en_o);

    // R9
    apply_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(act_div) || !$stable(act_fast)) |-> (clk_en_o || $past(act_div) == '0));
endmodule

bind cardclk_dualref cardclk_chk #(
    .FREQ_W (FREQ_W),
    .DIV_W  (DIV_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .req_hz_i   (req_hz_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .ref_fast_o (ref_fast_o),
    .div_o      (div_o),
    .clk_en_o   (clk_en_o),
    .act_div    (act_div),
    .act_fast   (act_fast),
    .lane_done  (lane_done)
);

// File: tb/cardclk_dualref_tb_top.sv
// Self-checking bench: request sweep with arithmetic expectations and
// strobe-period measurements on periodic reference ticks.
module cardclk_dualref_tb_top;
    localparam int  FW  = 25;
    localparam int  DW  = 10;
    localparam int  LAT = 2 * FW + 3;
    localparam int  PS  = 6;
    localparam int  PF  = 5;
    localparam longint F_SLOW = 20_000_000;
    localparam longint F_FAST = 24_000_000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [FW-1:0] req_hz_i = '0;
    logic          tick_slow_i = 1'b0;
    logic          tick_fast_i = 1'b0;
    logic          busy_o, done_o, ref_fast_o, clk_en_o;
    logic [DW-1:0] div_o;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    int sc = 0;
    int fc = 0;
    bit fin = 0;
    bit exp_fast = 0;

    cardclk_dualref dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .req_hz_i    (req_hz_i),
        .tick_slow_i (tick_slow_i),
        .tick_fast_i (tick_fast_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .ref_fast_o  (ref_fast_o),
        .div_o       (div_o),
        .clk_en_o    (clk_en_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // periodic reference ticks, driven away from the active edge
    always @(negedge clk) begin
        sc = (sc == PS - 1) ? 0 : sc + 1;
        fc = (fc == PF - 1) ? 0 : fc + 1;
        tick_slow_i = (sc == 0);
        tick_fast_i = (fc == 0);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint lane_div(input longint f, input longint q);
        longint d = f / q;
        if (d == 0) d = 1;
        if (f / d > q) d = d + 1;
        return d;
    endfunction

    task automatic finish_run();
        if (!fin) begin
            fin = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // issue a request; optionally inject a second start while busy
    task automatic run_req(input longint req, input bit inject, input longint req2);
        longint ds, dfst, fs, ff, ediv;
        bit     efast;
        int     c0, waited;
        if (req == 0) begin
            ediv  = 0;
            efast = exp_fast;
        end else begin
            ds    = lane_div(F_SLOW, req);
            dfst  = lane_div(F_FAST, req);
            fs    = F_SLOW / ds;
            ff    = F_FAST / dfst;
            efast = !(fs > ff);
            ediv  = (efast ? dfst : ds) % 1024;
        end
        @(negedge clk);
        start_i  = 1'b1;
        req_hz_i = FW'(req);
        @(negedge clk);
        start_i = 1'b0;
        c0 = cyc;
        waited = 0;
        while (!done_o && waited < 400) begin
            @(negedge clk);
            waited++;
            if (inject && waited == 3) begin
                start_i  = 1'b1;
                req_hz_i = FW'(req2);
            end else begin
                start_i = 1'b0;
            end
        end
        start_i = 1'b0;
        chk(cyc - c0 == (req == 0 ? 0 : LAT), req == 0 ? "R5" : "R6",
            $sformatf("done latency req=%0d", req), cyc - c0, req == 0 ? 0 : LAT);
        chk(div_o == DW'(ediv), "R2 R4", $sformatf("divider req=%0d", req), div_o, ediv);
        chk(ref_fast_o == efast, "R3", $sformatf("reference req=%0d", req), ref_fast_o, efast);
        exp_fast = efast;
    endtask

    task automatic wait_pulse(output int at);
        @(negedge clk);
        while (!clk_en_o) @(negedge clk);
        at = cyc;
    endtask

    // skip the adoption strobe, then measure a full new period
    task automatic gap_check(input int exp, input string req);
        int a, b, c;
        wait_pulse(a);
        wait_pulse(b);
        wait_pulse(c);
        chk(c - b == exp, req, "strobe period", c - b, exp);
    endtask

    initial begin
        int a, b, hits;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(div_o == DW'(61), "R1", "reset divider", div_o, 61);
        chk(ref_fast_o == 1'b0, "R1", "reset reference", ref_fast_o, 0);
        chk(!busy_o && !done_o, "R1", "reset busy/done", {busy_o, done_o}, 0);
        wait_pulse(a);
        wait_pulse(b);
        chk(b - a == 61 * PS, "R1", "reset strobe period", b - a, 61 * PS);

        // R8 periods on both references, divider 1 passes every tick
        run_req(24_000_000, 0, 0);
        gap_check(1 * PF, "R8");
        run_req(12_000_000, 0, 0);
        gap_check(2 * PF, "R8");

        // R5 zero request stops the strobe, reference unchanged
        run_req(0, 0, 0);
        wait_pulse(a);
        hits = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (clk_en_o) hits++;
        end
        chk(hits == 0, "R5 R8", "strobes while stopped", hits, 0);

        // R9 restart from stopped is adopted at once
        run_req(24_000_000, 0, 0);
        gap_check(1 * PF, "R9");
        run_req(5_000_000, 0, 0);
        gap_check(4 * PS, "R8");

        // R9 same-reference change: adoption strobe then exactly div new ticks
        run_req(10_000_000, 0, 0);
        wait_pulse(a);
        wait_pulse(b);
        chk(b - a == 2 * PS, "R9", "first period after adoption", b - a, 2 * PS);

        // R7 start while busy is ignored
        run_req(400_000, 1, 24_000_000);

        // R2 R3 R4 sweep around every divider boundary
        for (int n = 1; n <= 70; n++) begin
            run_req(F_SLOW / n, 0, 0);
            run_req(F_FAST / n, 0, 0);
            run_req(F_SLOW / n + 1, 0, 0);
            run_req(F_FAST / n - 1, 0, 0);
        end
        run_req(20_000, 0, 0);
        run_req(333_333, 0, 0);
        run_req(1, 0, 0);
        run_req(5, 0, 0);
        run_req(30_000_000, 0, 0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        finish_run();
    end
endmodule